// File: doc/BRIEF.md
# I2C Master Byte Engine

This block is the bus-side engine of a byte-oriented I2C master. A host works it through three writable registers: control, transmit data and clock control. It reads back the control bits, the last byte on the bus and a one-byte status code. Each host command runs one bus phase: a start, a stop, or a nine-bit byte phase made of eight data bits and an acknowledge bit. When a start or byte phase ends, the engine raises an interrupt flag. It then holds SCL low until the host clears the flag with its next command. The status code tells the host what the phase just did. The host never needs to sample the bus lines itself.

The engine drives both lines as open drain: a drive-low output per line, plus the resolved SDA level as an input. SCL timing comes from two stages: a power-of-two prescaler (N) and a linear divider (M) after a fixed base divider. Each SCL period is ten divided steps. SDA moves only while SCL is low, except on the start and stop edges. A transmitted 1 that reads back as 0 is treated as a lost arbitration, and the engine lets go of the bus.

Top module: `i2cm_byte_engine`

## Requirements
- R1: After reset the status reads 0xF8, the interrupt flag and the control readback are 0, and neither line is driven low.
- R2: A control write (select 0) with bit 6 (enable) and bit 5 (start) set on a free bus produces a start condition (SDA falls while SCL is high). The engine then reports status 0x08, raises the interrupt flag, and keeps SDA and SCL low.
- R3: After a start, the byte written at select 1 is sent most significant bit first and is run by a control write with enable set and bit 3 clear. With bit 0 = 0 this is address+write: a low SDA at the ninth SCL high gives 0x18, a high one gives 0x20.
- R4: A data byte sent after an acknowledged address+write reports 0x28 when acknowledged and 0x30 when not.
- R5: An address byte with bit 0 = 1 reports 0x40 when acknowledged and 0x48 when not, and later byte phases receive.
- R6: In a receive phase, the engine drives SDA low on the ninth bit when control bit 2 was set in the launching write and reports 0x50. When bit 2 was clear it releases SDA and reports 0x58. The received byte (first bit as MSB) appears at the data readback.
- R7: A start requested while the engine still owns the bus gives a repeated start condition and status 0x10.
- R8: A control write with enable and bit 4 (stop) set, issued while the bus is owned, makes SDA rise while SCL is high. It releases both lines and leaves status 0xF8 with the interrupt flag not raised.
- R9: The clock-control register (select 2) holds M in bits 6:3 and N in bits 2:0. The SCL period is BASE_DIV * 2^N * 10 * (M+1) clock cycles.
- R10: When SDA reads low during a transmit bit that the engine left released, it reports 0x38, raises the interrupt flag and releases both lines. A following start is then a plain start (0x08).
- R11: While the interrupt flag is set and the engine owns the bus, SCL stays driven low for as long as the host waits.
- R12: A control write with bit 6 clear changes nothing: no phase, no flag change, no change to the control bits.
- R13: During byte phases SDA changes only while SCL is low, so no start or stop condition appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 control, 1 data, 2 clock control |
| wr_data_i | input | 8 | Register write data |
| ctl_o | output | 8 | Control readback: enable bit 6, interrupt flag bit 3, acknowledge bit 2 |
| data_o | output | 8 | Last byte shifted on the bus, or host-written byte |
| status_o | output | 8 | Status code of the last completed phase |
| irq_o | output | 1 | Interrupt flag |
| scl_drive_low_o | output | 1 | Pull SCL low when 1 |
| sda_drive_low_o | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Resolved SDA line level |

## Verification
The bench builds the engine with BASE_DIV = 2. Each divider step then lasts only a few clocks, so a nine-bit phase is a few hundred cycles and a whole run of write, read, repeated-start and arbitration sequences fits easily. Two clock-control settings are used: M=1/N=1 and M=2/N=0. Together they exercise both the power-of-two stage and the linear stage, through the measured SCL period.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int M_W     = 4;
  localparam int N_W     = 3;
  localparam int STEP_W  = 4;
  localparam int BIT_W   = 4;
  localparam logic [STEP_W-1:0] LAST_STEP = 4'd9;
  localparam logic [BIT_W-1:0]  ACK_BIT   = 4'd8;

  localparam int CTL_AAK = 2;
  localparam int CTL_FLG = 3;
  localparam int CTL_STP = 4;
  localparam int CTL_STA = 5;
  localparam int CTL_ENA = 6;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CLK  = 2'd2;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NAK  = 8'h20;
  localparam logic [7:0] ST_TX_ACK  = 8'h28;
  localparam logic [7:0] ST_TX_NAK  = 8'h30;
  localparam logic [7:0] ST_ARB     = 8'h38;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NAK  = 8'h48;
  localparam logic [7:0] ST_RX_ACK  = 8'h50;
  localparam logic [7:0] ST_RX_NAK  = 8'h58;
  localparam logic [7:0] ST_IDLE    = 8'hF8;

  typedef enum logic [2:0] {PH_IDLE, PH_HOLD, PH_START, PH_BYTE, PH_STOP} phase_e;

  function automatic logic [7:0] byte_code(input logic addr, input logic rd,
                                           input logic tx, input logic ack,
                                           input logic aak);
    if (addr)    return rd ? (ack ? ST_AR_ACK : ST_AR_NAK) : (ack ? ST_AW_ACK : ST_AW_NAK);
    else if (tx) return ack ? ST_TX_ACK : ST_TX_NAK;
    else         return aak ? ST_RX_ACK : ST_RX_NAK;
  endfunction
endpackage

// File: rtl/i2cm_scl_div.sv
module i2cm_scl_div
  import i2cm_pkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  output logic           step_o
);
  localparam int PRE_W = (1 << N_W) - 1;

  logic             base_tick;
  logic [PRE_W-1:0] pre_cnt, pre_lim;
  logic [M_W-1:0]   m_cnt;
  logic             samp_tick;

  generate
    if (BASE_DIV <= 1) begin : g_no_base
      assign base_tick = run_i;
    end else begin : g_base
      localparam int BW = $clog2(BASE_DIV);
      logic [BW-1:0] base_cnt;
      assign base_tick = run_i && (base_cnt == BW'(BASE_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        base_cnt <= '0;
        else if (!run_i)    base_cnt <= '0;
        else if (base_tick) base_cnt <= '0;
        else                base_cnt <= base_cnt + 1'b1;
      end
    end
  endgenerate

  assign pre_lim   = PRE_W'((8'd1 << n_i) - 8'd1);
  assign samp_tick = base_tick && (pre_cnt == pre_lim);
  assign step_o    = samp_tick && (m_cnt == m_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      m_cnt   <= '0;
    end else if (!run_i) begin
      pre_cnt <= '0;
      m_cnt   <= '0;
    end else if (base_tick) begin
      pre_cnt <= samp_tick ? '0 : pre_cnt + 1'b1;
      if (samp_tick) m_cnt <= step_o ? '0 : m_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_phase_fsm.sv
module i2cm_phase_fsm
  import i2cm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_i,
  input  logic [7:0] tx_i,
  input  logic       aak_i,
  input  logic       sda_i,
  output logic       run_o,
  output logic       own_o,
  output logic       cond_o,
  output logic       done_o,
  output logic [7:0] status_o,
  output logic [7:0] rx_o,
  output logic       scl_low_o,
  output logic       sda_low_o
);
  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;
  logic [BIT_W-1:0]  bit_q;
  logic [7:0]        sh_q, status_q;
  logic rep_q, addr_q, rd_q, tx_q, ack_q, aak_q, done_q, scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;  step_q <= '0;  bit_q <= '0;  sh_q <= '0;
      status_q <= ST_IDLE; rep_q <= 1'b0; addr_q <= 1'b0; rd_q <= 1'b0;
      tx_q <= 1'b0; ack_q <= 1'b0; aak_q <= 1'b0; done_q <= 1'b0;
      scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE, PH_HOLD: begin
          if (start_i) begin
            phase_q <= PH_START;
            rep_q   <= (phase_q == PH_HOLD);
            step_q  <= '0;
          end else if (stop_i && phase_q == PH_HOLD) begin
            phase_q <= PH_STOP;
            step_q  <= '0;
          end else if (byte_i && phase_q == PH_HOLD) begin
            phase_q <= PH_BYTE;
            step_q  <= '0;
            bit_q   <= '0;
            sh_q    <= tx_i;
            tx_q    <= addr_q || !rd_q;
            aak_q   <= aak_i;
            if (addr_q) rd_q <= tx_i[0];
          end
        end
        PH_START: if (step_i) begin
          if (step_q == 4'd0) sda_q <= 1'b0;
          if (step_q == 4'd3) scl_q <= 1'b0;
          if (step_q == 4'd6) sda_q <= 1'b1;
          if (step_q == LAST_STEP) begin
            scl_q    <= 1'b1;
            phase_q  <= PH_HOLD;
            status_q <= rep_q ? ST_RSTART : ST_START;
            done_q   <= 1'b1;
            addr_q   <= 1'b1;
          end else step_q <= step_q + 1'b1;
        end
        PH_BYTE: if (step_i) begin
          step_q <= (step_q == LAST_STEP) ? '0 : step_q + 1'b1;
          if (step_q == 4'd0)
            sda_q <= (bit_q < ACK_BIT) ? (tx_q & ~sh_q[7]) : (~tx_q & aak_q);
          if (step_q == 4'd5) scl_q <= 1'b0;
          if (step_q == 4'd7) begin
            if (bit_q < ACK_BIT) begin
              sh_q <= {sh_q[6:0], sda_i};
              // released a 1, read a 0: another master owns the bus
              if (tx_q && !sda_q && !sda_i) begin
                phase_q  <= PH_IDLE;
                scl_q    <= 1'b0;
                status_q <= ST_ARB;
                done_q   <= 1'b1;
                addr_q   <= 1'b0;
              end
            end else ack_q <= !sda_i;
          end
          if (step_q == LAST_STEP) begin
            scl_q <= 1'b1;
            if (bit_q == ACK_BIT) begin
              phase_q  <= PH_HOLD;
              status_q <= byte_code(addr_q, rd_q, tx_q, ack_q, aak_q);
              done_q   <= 1'b1;
              addr_q   <= 1'b0;
            end else bit_q <= bit_q + 1'b1;
          end
        end
        PH_STOP: if (step_i) begin
          if (step_q == 4'd0) sda_q <= 1'b1;
          if (step_q == 4'd3) scl_q <= 1'b0;
          if (step_q == 4'd6) sda_q <= 1'b0;
          if (step_q == LAST_STEP) begin
            phase_q  <= PH_IDLE;
            status_q <= ST_IDLE;
            addr_q   <= 1'b0;
          end else step_q <= step_q + 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign run_o     = (phase_q == PH_START) || (phase_q == PH_BYTE) || (phase_q == PH_STOP);
  assign own_o     = (phase_q == PH_HOLD);
  assign cond_o    = (phase_q == PH_START) || (phase_q == PH_STOP);
  assign done_o    = done_q;
  assign status_o  = status_q;
  assign rx_o      = sh_q;
  assign scl_low_o = scl_q;
  assign sda_low_o = sda_q;
endmodule

// File: rtl/i2cm_byte_engine.sv
module i2cm_byte_engine
  import i2cm_pkg::*;
#(
  parameter int BASE_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] ctl_o,
  output logic [7:0] data_o,
  output logic [7:0] status_o,
  output logic       irq_o,
  output logic       scl_drive_low_o,
  output logic       sda_drive_low_o,
  input  logic       sda_i
);
  logic             aak_q, ena_q, iflg_q;
  logic [7:0]       data_q;
  logic [M_W+N_W-1:0] clk_q;
  logic             phase_run, bus_own, cond_phase, phase_done, step_tick;
  logic [7:0]       rx_byte;
  logic             ctl_go, start_cmd, stop_cmd, byte_cmd;

  // control writes count only with enable set and no phase in flight
  assign ctl_go    = wr_en_i && (wr_sel_i == SEL_CTL) && !phase_run && wr_data_i[CTL_ENA];
  assign start_cmd = ctl_go && wr_data_i[CTL_STA];
  assign stop_cmd  = ctl_go && !wr_data_i[CTL_STA] && wr_data_i[CTL_STP] && bus_own;
  assign byte_cmd  = ctl_go && !wr_data_i[CTL_STA] && !wr_data_i[CTL_STP]
                   && !wr_data_i[CTL_FLG] && bus_own && iflg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aak_q  <= 1'b0;
      ena_q  <= 1'b0;
      iflg_q <= 1'b0;
      data_q <= '0;
      clk_q  <= '0;
    end else begin
      if (ctl_go) begin
        aak_q <= wr_data_i[CTL_AAK];
        ena_q <= 1'b1;
        if (!wr_data_i[CTL_FLG]) iflg_q <= 1'b0;
      end
      if (phase_done) begin
        iflg_q <= 1'b1;
        data_q <= rx_byte;
      end
      if (wr_en_i && !phase_run && wr_sel_i == SEL_DATA) data_q <= wr_data_i;
      if (wr_en_i && !phase_run && wr_sel_i == SEL_CLK)  clk_q  <= wr_data_i[M_W+N_W-1:0];
    end
  end

  i2cm_scl_div #(.BASE_DIV(BASE_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (phase_run),
    .m_i    (clk_q[M_W+N_W-1:N_W]),
    .n_i    (clk_q[N_W-1:0]),
    .step_o (step_tick)
  );

  i2cm_phase_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_tick),
    .start_i   (start_cmd),
    .stop_i    (stop_cmd),
    .byte_i    (byte_cmd),
    .tx_i      (data_q),
    .aak_i     (wr_data_i[CTL_AAK]),
    .sda_i     (sda_i),
    .run_o     (phase_run),
    .own_o     (bus_own),
    .cond_o    (cond_phase),
    .done_o    (phase_done),
    .status_o  (status_o),
    .rx_o      (rx_byte),
    .scl_low_o (scl_drive_low_o),
    .sda_low_o (sda_drive_low_o)
  );

  assign ctl_o  = {1'b0, ena_q, 2'b00, iflg_q, aak_q, 2'b00};
  assign data_o = data_q;
  assign irq_o  = iflg_q;
endmodule

// File: rtl/i2cm_byte_engine_chk.sv
module i2cm_byte_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       irq_i,
  input logic       own_i,
  input logic       cond_i,
  input logic [7:0] status_i,
  input logic       scl_low_i,
  input logic       sda_low_i
);
  p_hold_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && own_i) |-> scl_low_i);

  p_sda_quiet_scl_high_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(scl_low_i) && !scl_low_i && !$past(cond_i)) |-> $stable(sda_low_i));

  p_irq_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> (status_i != 8'hF8 && status_i[2:0] == 3'd0));

  p_stop_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 8'hF8 && $past(status_i) != 8'hF8) |-> (!scl_low_i && !sda_low_i && !$rose(irq_i)));

  p_arb_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i == 8'h38 && $past(status_i) != 8'h38) |-> (!scl_low_i && !sda_low_i));
endmodule

bind i2cm_byte_engine i2cm_byte_engine_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_i     (irq_o),
  .own_i     (bus_own),
  .cond_i    (cond_phase),
  .status_i  (status_o),
  .scl_low_i (scl_drive_low_o),
  .sda_low_i (sda_drive_low_o)
);

// File: tb/i2cm_byte_engine_test.sv
`timescale 1ns/1ps
module i2cm_byte_engine_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] ctl_o, data_o, status_o;
  logic       irq_o, scl_drive_low_o, sda_drive_low_o;
  logic       slave_low = 1'b0;
  wire        sda_line = !(sda_drive_low_o || slave_low);
  wire        scl_line = !scl_drive_low_o;

  always #5 clk_i = ~clk_i;

  i2cm_byte_engine #(.BASE_DIV(2)) uut (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i, .ctl_o, .data_o,
    .status_o, .irq_o, .scl_drive_low_o, .sda_drive_low_o, .sda_i(sda_line)
  );

  int n_chk = 0, n_fail = 0, starts = 0, stops = 0;
  logic [8:0] bus_bits = '0;
  realtime rise_t = 0.0, period_t = 0.0;
  bit finished = 1'b0;

  always @(negedge sda_line) if (scl_line === 1'b1) starts++;
  always @(posedge sda_line) if (scl_line === 1'b1) stops++;
  always @(posedge scl_line) begin
    period_t = $realtime - rise_t;
    rise_t   = $realtime;
    bus_bits = {bus_bits[7:0], sda_line};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_irq;
    wait (irq_o === 1'b1);
    @(negedge clk_i);
  endtask

  task automatic do_start(input logic [7:0] exp, input string req);
    int s0 = starts;
    wr(2'd0, 8'h60);
    wait_irq();
    chk(req, status_o, exp);
    chk(req, starts, s0 + 1);
    chk(req, scl_drive_low_o, 1'b1);
  endtask

  task automatic do_byte(input bit aak, input logic [8:0] pat, input logic [7:0] exp, input string req);
    int s0 = starts;
    int p0 = stops;
    slave_low = !pat[8];
    wr(2'd0, aak ? 8'h44 : 8'h40);
    for (int k = 1; k < 9; k++) begin
      @(negedge scl_line);
      slave_low = !pat[8-k];
    end
    wait_irq();
    slave_low = 1'b0;
    chk(req, status_o, exp);
    chk("R13", starts + stops, s0 + p0);
  endtask

  task automatic do_stop(input string req);
    int p0 = stops;
    wr(2'd0, 8'h50);
    wait (status_o === 8'hF8);
    @(negedge clk_i);
    chk(req, irq_o, 1'b0);
    chk(req, stops, p0 + 1);
    chk(req, {scl_drive_low_o, sda_drive_low_o}, 2'b00);
  endtask

  task automatic t_reset;
    chk("R1", status_o, 8'hF8);
    chk("R1", irq_o, 1'b0);
    chk("R1", ctl_o, 8'h00);
    chk("R1", {scl_drive_low_o, sda_drive_low_o}, 2'b00);
  endtask

  task automatic t_write;
    wr(2'd2, 8'h09);                       // M=1 N=1
    do_start(8'h08, "R2");
    chk("R2", sda_drive_low_o, 1'b1);
    repeat (300) @(negedge clk_i);
    chk("R11", scl_drive_low_o, 1'b1);
    chk("R11", irq_o, 1'b1);
    wr(2'd0, 8'h04);                       // no enable
    repeat (300) @(negedge clk_i);
    chk("R12", status_o, 8'h08);
    chk("R12", irq_o, 1'b1);
    chk("R12", ctl_o[2], 1'b0);
    chk("R12", scl_drive_low_o, 1'b1);
    wr(2'd1, 8'hA0);
    do_byte(1'b0, 9'h1FE, 8'h18, "R3");
    chk("R3", bus_bits, {8'hA0, 1'b0});
    chk("R9", $rtoi(period_t), 800);
    wr(2'd1, 8'h3C);
    do_byte(1'b0, 9'h1FE, 8'h28, "R4");
    chk("R4", bus_bits[8:1], 8'h3C);
    wr(2'd1, 8'h81);
    do_byte(1'b0, 9'h1FF, 8'h30, "R4");
    do_stop("R8");
  endtask

  task automatic t_addr_nack;
    do_start(8'h08, "R2");
    wr(2'd1, 8'hA0);
    do_byte(1'b0, 9'h1FF, 8'h20, "R3");
    chk("R3", bus_bits[0], 1'b1);
    do_stop("R8");
  endtask

  task automatic t_read;
    wr(2'd2, 8'h10);                       // M=2 N=0
    do_start(8'h08, "R2");
    wr(2'd1, 8'hA1);
    do_byte(1'b0, 9'h1FE, 8'h40, "R5");
    chk("R9", $rtoi(period_t), 600);
    do_byte(1'b1, {8'h5A, 1'b1}, 8'h50, "R6");
    chk("R6", data_o, 8'h5A);
    chk("R6", bus_bits[0], 1'b0);
    do_byte(1'b0, {8'hC3, 1'b1}, 8'h58, "R6");
    chk("R6", data_o, 8'hC3);
    chk("R6", bus_bits[0], 1'b1);
    do_start(8'h10, "R7");
    wr(2'd1, 8'hA1);
    do_byte(1'b0, 9'h1FF, 8'h48, "R5");
    do_stop("R8");
  endtask

  task automatic t_arb;
    do_start(8'h08, "R10");
    wr(2'd1, 8'hFF);
    slave_low = 1'b1;
    wr(2'd0, 8'h40);
    wait_irq();
    chk("R10", status_o, 8'h38);
    chk("R10", {scl_drive_low_o, sda_drive_low_o}, 2'b00);
    slave_low = 1'b0;
    repeat (5) @(negedge clk_i);
    do_start(8'h08, "R10");
    do_stop("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_write();
    t_addr_nack();
    t_read();
    t_arb();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0h exp=%0h", status_o, 8'hF8);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule